// File: doc/BRIEF.md
# Byte-Serial to Word FIFO Data Engine

This block sits between a word-wide host side and a byte-wide card data port. It holds a small FIFO of 32-bit words and moves data one byte per clock through it. A byte counter is loaded from a 16-bit length register when software writes the control register with the enable bit set. The control register also gives the transfer direction.

When the transfer reads from the card, the block gathers incoming bytes into words, lowest byte first, and pushes each word into the FIFO for the host to pop. When the transfer writes to the card, the host pushes words and the block sends their bytes, lowest byte first.

The block reports sticky end-of-transfer flags and occupancy flags for the active direction. It clears its own enable bit once the count has run out and the FIFO is empty.

Top module: `byte_word_mover`

## Requirements
- R1: After reset the control register, the length register, the byte counter and the FIFO occupancy are zero, `host_rdata` is zero and every bit of `flags` is zero.
- R2: A control write stores `ctrl_wdata`. Bit 0 is enable and bit 1 is direction (1 = card to FIFO); bits 2 and 3 are only stored. When bit 0 is set, the same write loads the byte counter from the 16-bit length register.
- R3: In the read direction, one card byte is taken per cycle (`card_rx_take`) while the count is nonzero and `card_rdy` is high. Each byte decrements the counter. Bytes are packed little-endian, with the first byte in bits 7:0, and every fourth byte completes a word that is pushed into the FIFO.
- R4: If the count reaches zero part-way through a word, that partial word is pushed with its unfilled upper bytes set to zero.
- R5: A read stalls, with the counter unchanged, while `card_rdy` is low or while the FIFO holds DEPTH (16) words.
- R6: In the write direction, the block pops a word and presents its four bytes on `card_tx_byte` with `card_tx_valid`, LSB first, one per cycle. The counter drops by one per byte. Bytes left in a word when the count reaches zero are dropped.
- R7: While enabled with a zero count, data-end (`flags[8]`) and block-end (`flags[10]`) become set and stay set. A `clr_we` pulse clears data-end where `clr_mask[0]` is 1 and block-end where `clr_mask[1]` is 1.
- R8: While enabled, with a zero count and an empty FIFO, the block clears control bit 0 on the next clock.
- R9: While enabled, the occupancy flags depend on the direction. In the read direction: active = bit 13, half-full (at least 8 words) = bit 15, full (16) = bit 17, empty = bit 19, data available = bit 21. In the write direction: active = bit 12, half-empty (at most 8 words) = bit 14, full = bit 16, empty = bit 18, data available = bit 20. The other group reads zero, and all of bits 21:12 are zero when not enabled.
- R10: A host push is ignored when the FIFO is full, the count is zero, or the direction is read. A host pop is ignored when the FIFO is empty or the direction is write, and `host_rdata` then reads zero.
- R11: FIFO occupancy never exceeds DEPTH, and it changes only on a push or a pop.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ctrl_we | input | 1 | Write strobe for the control register |
| ctrl_wdata | input | 4 | Control value: enable, direction, mode, DMA enable |
| len_we | input | 1 | Write strobe for the length register |
| len_wdata | input | LEN_W | Transfer length in bytes |
| clr_we | input | 1 | Clear strobe for the sticky flags |
| clr_mask | input | 2 | Bit 0 clears data-end, bit 1 clears block-end |
| host_push | input | 1 | Host pushes a word into the FIFO |
| host_wdata | input | 32 | Word pushed by the host |
| host_pop | input | 1 | Host pops the head word |
| host_rdata | output | 32 | Head word visible to the host, zero when none |
| card_rdy | input | 1 | Card has read data ready |
| card_rx_byte | input | 8 | Byte offered by the card |
| card_rx_take | output | 1 | Block consumes `card_rx_byte` this cycle |
| card_tx_valid | output | 1 | Block sends `card_tx_byte` this cycle |
| card_tx_byte | output | 8 | Byte sent to the card |
| ctrl_q | output | 4 | Control register |
| byte_cnt | output | LEN_W | Remaining byte count |
| fifo_level | output | $clog2(DEPTH)+1 | FIFO occupancy in words |
| flags | output | 22 | Status flags, bit positions as in R7 and R9 |

## Verification
The bench builds the block with its default parameters: DEPTH of 16 words and a 16-bit length. A length of 80 bytes is longer than the 64 bytes the FIFO can hold, so the full flag, the stall on a full FIFO and the resume after a single pop are all exercised. Lengths of 6 and 8 bytes cover the trailing partial word on both the read side and the write side. A zero length reaches the immediate end-of-transfer path.

// File: rtl/byte_word_mover.sv
module byte_word_mover #(
  parameter int DEPTH = 16,
  parameter int LEN_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ctrl_we,
  input  logic [3:0]        ctrl_wdata,
  input  logic              len_we,
  input  logic [LEN_W-1:0]  len_wdata,
  input  logic              clr_we,
  input  logic [1:0]        clr_mask,
  input  logic              host_push,
  input  logic [31:0]       host_wdata,
  input  logic              host_pop,
  output logic [31:0]       host_rdata,
  input  logic              card_rdy,
  input  logic [7:0]        card_rx_byte,
  output logic              card_rx_take,
  output logic              card_tx_valid,
  output logic [7:0]        card_tx_byte,
  output logic [3:0]        ctrl_q,
  output logic [LEN_W-1:0]  byte_cnt,
  output logic [$clog2(DEPTH):0] fifo_level,
  output logic [21:0]       flags
);
  localparam int AW    = $clog2(DEPTH);
  localparam int LVL_W = AW + 1;
  localparam logic [LVL_W-1:0] FULL_LVL = LVL_W'(DEPTH);
  localparam logic [LVL_W-1:0] HALF_LVL = LVL_W'(DEPTH / 2);

  logic [31:0]      mem [DEPTH];
  logic [AW-1:0]    rd_ptr;
  logic [LEN_W-1:0] len_q;
  logic [31:0]      pack_q;
  logic [1:0]       lane;
  logic [23:0]      tx_sh;
  logic [1:0]       tx_left;
  logic             dend_q, bend_q;

  logic en, rd_dir, full, empty, cnt_nz;
  assign en     = ctrl_q[0];
  assign rd_dir = ctrl_q[1];
  assign full   = fifo_level == FULL_LVL;
  assign empty  = fifo_level == '0;
  assign cnt_nz = byte_cnt != '0;

  logic [31:0] head, pack_word;
  assign head      = mem[rd_ptr];
  assign pack_word = pack_q | ({24'b0, card_rx_byte} << {lane, 3'b000});

  assign card_rx_take  = en && rd_dir && cnt_nz && card_rdy && !full && !ctrl_we;
  assign card_tx_valid = en && !rd_dir && cnt_nz && (tx_left != 2'd0 || !empty) && !ctrl_we;
  assign card_tx_byte  = (tx_left != 2'd0) ? tx_sh[7:0] : head[7:0];

  logic eng_push, eng_pop, h_push, h_pop, do_push, do_pop;
  assign eng_push = card_rx_take && (lane == 2'd3 || byte_cnt == LEN_W'(1));
  assign eng_pop  = card_tx_valid && tx_left == 2'd0;
  assign h_push   = host_push && !rd_dir && cnt_nz && !full && !ctrl_we;
  assign h_pop    = host_pop && rd_dir && !empty;
  assign do_push  = eng_push || h_push;
  assign do_pop   = eng_pop || h_pop;

  assign host_rdata = (rd_dir && !empty) ? head : 32'd0;

  logic [AW-1:0] wr_idx;
  assign wr_idx = rd_ptr + fifo_level[AW-1:0];

  always_ff @(posedge clk) begin
    if (do_push) mem[wr_idx] <= eng_push ? pack_word : host_wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_ptr     <= '0;
      fifo_level <= '0;
    end else begin
      if (do_pop) rd_ptr <= rd_ptr + 1'b1;
      if (do_push && !do_pop)      fifo_level <= fifo_level + 1'b1;
      else if (do_pop && !do_push) fifo_level <= fifo_level - 1'b1;
    end
  end

  logic finish;
  assign finish = en && !cnt_nz && !ctrl_we;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q   <= '0;
      len_q    <= '0;
      byte_cnt <= '0;
      pack_q   <= '0;
      lane     <= '0;
      tx_sh    <= '0;
      tx_left  <= '0;
    end else begin
      if (len_we) len_q <= len_wdata;
      if (ctrl_we) begin
        ctrl_q  <= ctrl_wdata;
        if (ctrl_wdata[0]) byte_cnt <= len_q;
        pack_q  <= '0;
        lane    <= '0;
        tx_left <= '0;
      end else begin
        if (finish && empty) ctrl_q[0] <= 1'b0;
        if (card_rx_take || card_tx_valid) byte_cnt <= byte_cnt - 1'b1;
        if (card_rx_take) begin
          if (eng_push) begin
            pack_q <= '0;
            lane   <= '0;
          end else begin
            pack_q <= pack_word;
            lane   <= lane + 1'b1;
          end
        end
        if (card_tx_valid) begin
          if (eng_pop) begin
            tx_sh   <= head[31:8];
            tx_left <= 2'd3;
          end else begin
            tx_sh   <= tx_sh >> 8;
            tx_left <= tx_left - 1'b1;
          end
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dend_q <= 1'b0;
      bend_q <= 1'b0;
    end else begin
      if (finish) begin
        dend_q <= 1'b1;
        bend_q <= 1'b1;
      end else if (clr_we) begin
        if (clr_mask[0]) dend_q <= 1'b0;
        if (clr_mask[1]) bend_q <= 1'b0;
      end
    end
  end

  logic rx_on, tx_on;
  assign rx_on = en && rd_dir;
  assign tx_on = en && !rd_dir;

  assign flags[7:0] = '0;
  assign flags[8]   = dend_q;
  assign flags[9]   = 1'b0;
  assign flags[10]  = bend_q;
  assign flags[11]  = 1'b0;
  assign flags[12]  = tx_on;
  assign flags[13]  = rx_on;
  assign flags[14]  = tx_on && fifo_level <= HALF_LVL;
  assign flags[15]  = rx_on && fifo_level >= HALF_LVL;
  assign flags[16]  = tx_on && full;
  assign flags[17]  = rx_on && full;
  assign flags[18]  = tx_on && empty;
  assign flags[19]  = rx_on && empty;
  assign flags[20]  = tx_on && !empty;
  assign flags[21]  = rx_on && !empty;

  // R11
  level_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_level <= FULL_LVL);

  // R11
  level_still_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!do_push && !do_pop) |=> fifo_level == $past(fifo_level));

  // R3
  cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (card_rx_take || card_tx_valid) |=> byte_cnt == $past(byte_cnt) - 1'b1);

  // R8
  en_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !cnt_nz && empty && !ctrl_we) |=> !ctrl_q[0]);

  // R7
  end_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    finish |=> (flags[8] && flags[10]));
endmodule

// File: tb/byte_word_mover_tb.sv
module byte_word_mover_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic        ctrl_we = 0, len_we = 0, clr_we = 0, host_push = 0, host_pop = 0, card_rdy = 0;
  logic [3:0]  ctrl_wdata = 0;
  logic [15:0] len_wdata = 0;
  logic [1:0]  clr_mask = 0;
  logic [31:0] host_wdata = 0;
  logic [7:0]  card_rx_byte;
  logic [31:0] host_rdata;
  logic        card_rx_take, card_tx_valid;
  logic [7:0]  card_tx_byte;
  logic [3:0]  ctrl_q;
  logic [15:0] byte_cnt;
  logic [4:0]  fifo_level;
  logic [21:0] flags;

  byte_word_mover dut_i (.*);

  int checks = 0, errors = 0;
  logic [7:0] rx_idx = 0;
  assign card_rx_byte = rx_idx;
  always @(posedge clk) if (card_rx_take) rx_idx <= rx_idx + 1'b1;

  logic [7:0] txlog [16];
  int txn = 0;
  always @(posedge clk) if (card_tx_valid) begin
    if (txn < 16) txlog[txn] <= card_tx_byte;
    txn <= txn + 1;
  end

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] wexp(logic [7:0] start, int k, int total);
    logic [31:0] w = 0;
    for (int b = 0; b < 4; b++)
      if (4 * k + b < total) w[8*b +: 8] = start + 8'(4 * k + b);
    return w;
  endfunction

  task automatic start_xfer(logic [15:0] len, logic [3:0] ctl);
    @(negedge clk); len_we = 1; len_wdata = len;
    @(negedge clk); len_we = 0; ctrl_we = 1; ctrl_wdata = ctl;
    @(negedge clk); ctrl_we = 0;
  endtask

  task automatic wait_cnt_zero();
    for (int i = 0; i < 500 && byte_cnt != 0; i++) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  task automatic drain(string req, logic [7:0] start, int nwords, int total);
    for (int k = 0; k < nwords; k++) begin
      @(negedge clk); host_pop = 0;
      for (int i = 0; i < 500 && fifo_level == 0; i++) @(negedge clk);
      check(req, host_rdata, wexp(start, k, total));
      host_pop = 1;
    end
    @(negedge clk); host_pop = 0;
    repeat (2) @(negedge clk);
  endtask

  task automatic t_reset();
    check("R1 ctrl", 32'(ctrl_q), 0);
    check("R1 cnt", 32'(byte_cnt), 0);
    check("R1 level", 32'(fifo_level), 0);
    check("R1 flags", 32'(flags), 0);
    check("R1 rdata", host_rdata, 0);
  endtask

  task automatic t_read_full_words();
    logic [7:0] s;
    card_rdy = 0;
    start_xfer(16'd8, 4'b1011);
    check("R2 ctrl stored", 32'(ctrl_q), 32'hB);
    check("R2 cnt loaded", 32'(byte_cnt), 8);
    repeat (5) @(negedge clk);
    check("R5 stall rdy low", 32'(byte_cnt), 8);
    check("R9 rx empty flags", 32'(flags[21:12]), 32'h082);
    s = rx_idx;
    card_rdy = 1;
    wait_cnt_zero();
    check("R3 level", 32'(fifo_level), 2);
    check("R7 end flags", 32'(flags[10:8]), 3'b101);
    check("R9 rx avail flags", 32'(flags[21:12]), 32'h202);
    drain("R3 word", s, 2, 8);
    check("R8 enable cleared", 32'(ctrl_q[0]), 0);
    check("R9 flags off", 32'(flags[21:12]), 0);
  endtask

  task automatic t_read_partial();
    logic [7:0] s;
    s = rx_idx;
    start_xfer(16'd6, 4'b0011);
    wait_cnt_zero();
    check("R4 level", 32'(fifo_level), 2);
    drain("R4 word", s, 2, 6);
    check("R8 enable cleared", 32'(ctrl_q[0]), 0);
  endtask

  task automatic t_read_fifo_full();
    logic [7:0] s;
    s = rx_idx;
    start_xfer(16'd80, 4'b0011);
    repeat (80) @(negedge clk);
    check("R5 cnt at full", 32'(byte_cnt), 16);
    check("R5 level full", 32'(fifo_level), 16);
    check("R9 rx full flags", 32'(flags[21:12]), 32'h22A);
    check("R10 push in read ignored", 32'(fifo_level), 16);
    drain("R5 word", s, 20, 80);
    check("R8 enable cleared", 32'(ctrl_q[0]), 0);
    check("R3 level empty", 32'(fifo_level), 0);
  endtask

  task automatic t_write();
    txn = 0;
    start_xfer(16'd6, 4'b0001);
    check("R9 tx empty flags", 32'(flags[21:12]), 32'h045);
    host_push = 1; host_wdata = 32'h44332211;
    @(negedge clk); host_wdata = 32'h88776655;
    @(negedge clk); host_push = 0;
    wait_cnt_zero();
    check("R6 byte count", 32'(txn), 6);
    for (int i = 0; i < 6; i++)
      check("R6 byte", 32'(txlog[i]), 32'(8'h11 * (i + 1)));
    check("R8 enable cleared", 32'(ctrl_q[0]), 0);
    check("R6 level", 32'(fifo_level), 0);
  endtask

  task automatic t_zero_len_and_clear();
    clr_we = 0;
    @(negedge clk); clr_we = 1; clr_mask = 2'b11;
    @(negedge clk); clr_we = 0;
    check("R7 cleared", 32'(flags[10:8]), 0);
    start_xfer(16'd0, 4'b0001);
    repeat (2) @(negedge clk);
    check("R7 zero length end", 32'(flags[10:8]), 3'b101);
    check("R8 zero length disable", 32'(ctrl_q[0]), 0);
    @(negedge clk); clr_we = 1; clr_mask = 2'b01;
    @(negedge clk); clr_we = 0;
    check("R7 clear data-end only", 32'(flags[10:8]), 3'b100);
    host_push = 1; host_wdata = 32'hDEAD;
    @(negedge clk); host_push = 0;
    check("R10 push zero count ignored", 32'(fifo_level), 0);
    @(negedge clk); ctrl_we = 1; ctrl_wdata = 4'b0010;
    @(negedge clk); ctrl_we = 0; host_pop = 1;
    check("R10 empty pop data", host_rdata, 0);
    @(negedge clk); host_pop = 0;
    check("R10 empty pop level", 32'(fifo_level), 0);
  endtask

  initial begin
    #(20 * 150000);
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    @(negedge clk);
    t_read_full_words();
    t_read_partial();
    t_read_fifo_full();
    t_write();
    t_zero_len_and_clear();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule